// File: doc/BRIEF.md
# VSYNC-clocked EDID serial transmitter

This block sends display identification bytes one way, from a local byte buffer onto a single data line. It uses the incoming vertical sync signal as its bit clock. The system clock samples that signal through a synchronizer and a rising-edge detector, and every change of state happens on a detected rising edge.

Transmission starts once the enable bit is high and the software-access bit is low. The line first stays released (high impedance) for a synchronization phase of nine VSYNC periods. After that the block sends bytes continuously, one bit per VSYNC period. Each byte is sent most significant bit first and is followed by one released period, so a byte takes a frame of nine periods.

After every byte the buffer pointer advances and a one-clock interrupt pulse marks the byte boundary. The pointer advances only inside the selected identification region of 128 or 256 bytes, and it wraps to zero after the region's last location. While software access is on, the transmitter is idle. During that time software can load the same pointer or step it under the same region rule.

Top module: `ddc1_edid_tx`

## Requirements
- R1: Once enabled (enable high, software access low), the data line stays released (sda_oe = 0) for the first 9 detected VSYNC rising edges. Bit B7 of the byte at the pointer is driven from the 10th rising edge on.
- R2: Each byte is driven most significant bit first, one bit per VSYNC period, for 8 periods (sda_oe = 1, sda_out = the bit). It is followed by one period with sda_oe = 0. The next byte's B7 then follows with no gap.
- R3: With size_256 = 1 the pointer steps through all 256 locations, and after location 255 it wraps to 0.
- R4: After each transmitted byte the pointer advances by one, so the next frame carries the next buffer location.
- R5: With size_256 = 0 the region is locations 0 to 127. After location 127 the pointer wraps to 0.
- R6: With size_256 = 0, a pointer at 128 or above is not advanced by a step, whether the step comes from software or from a byte boundary. Software can still load such a location directly.
- R7: byte_irq is a single system-clock pulse issued once per transmitted byte, when that byte's released slot begins.
- R8: While sw_access = 1 the data line is released and no bits are sent. sw_ptr_we loads the pointer with sw_ptr_wdata, and sw_step advances it under the region rule.
- R9: Clearing the enable bit releases the line within two system clocks at any point in a frame. The next enable starts a new 9-period synchronization phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Vertical sync, used as the bit clock (asynchronous) |
| tx_enable | input | 1 | Transmission enable |
| size_256 | input | 1 | Region select: 0 = 128 bytes, 1 = 256 bytes |
| sw_access | input | 1 | Software access to the buffer; holds the transmitter idle |
| sw_ptr_we | input | 1 | Load the pointer (only while sw_access = 1) |
| sw_ptr_wdata | input | 8 | Value to load into the pointer |
| sw_step | input | 1 | Software post-increment request (only while sw_access = 1) |
| buf_addr | output | 8 | Buffer read address (the pointer) |
| buf_rdata | input | 8 | Buffer byte at buf_addr |
| sda_oe | output | 1 | Data line drive enable (0 = high impedance) |
| sda_out | output | 1 | Data line value while driven |
| byte_irq | output | 1 | One-clock pulse per transmitted byte |

## Verification
The bench builds the block with its default parameters: a 256-location buffer, 8-bit data, a 9-edge synchronization phase and a two-flop synchronizer. With these values both region sizes can be exercised, so the wrap at 127 and the wrap at 255 are both driven from pointers loaded near the region end. The released upper half of the 128-byte setting is probed by loading location 200 and stepping it. Each VSYNC period lasts 16 system clocks, which leaves the three-clock synchronizer latency well settled before every sample.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SYNC = 2'd1,
      PH_DATA = 2'd2
   } ddc1_phase_e;
endpackage

// File: rtl/ddc1_vsync_edge.sv
module ddc1_vsync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("ddc1_vsync_edge: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/ddc1_pointer.sv
module ddc1_pointer #(
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          size_full,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST_FULL = AW'(DEPTH - 1);
   localparam logic [AW-1:0] LAST_HALF = AW'(DEPTH / 2 - 1);

   logic [AW-1:0] region_last;
   logic [AW-1:0] stepped;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad
         $error("ddc1_pointer: DEPTH must be a power of two, at least 4");
      end
   endgenerate

   always_comb begin
      region_last = size_full ? LAST_FULL : LAST_HALF;
      if (ptr == region_last)     stepped = '0;
      else if (ptr < region_last) stepped = ptr + AW'(1);
      else                        stepped = ptr;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (step) ptr <= stepped;
endmodule

// File: rtl/ddc1_framer.sv
module ddc1_framer
   import ddc1_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_EDGES  = 9,
   localparam int SCW        = $clog2(SYNC_EDGES + 1),
   localparam int SLW        = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rise,
   input  logic [DATA_W-1:0] byte_in,
   output logic              line_oe,
   output logic              line_out,
   output logic              byte_done
);
   localparam logic [SCW-1:0] SYNC_END = SCW'(SYNC_EDGES);
   localparam logic [SLW-1:0] HIZ_SLOT = SLW'(DATA_W);

   ddc1_phase_e       phase;
   logic [SCW-1:0]    sync_cnt;
   logic [SLW-1:0]    slot;
   logic [DATA_W-1:0] shreg;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("ddc1_framer: DATA_W must be at least 2");
      end
      if (SYNC_EDGES < 1) begin : g_bad_s
         $error("ddc1_framer: SYNC_EDGES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         sync_cnt  <= '0;
         slot      <= '0;
         shreg     <= '0;
         line_oe   <= 1'b0;
         line_out  <= 1'b0;
         byte_done <= 1'b0;
      end else if (!run) begin
         phase     <= PH_IDLE;
         sync_cnt  <= '0;
         slot      <= '0;
         line_oe   <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               phase    <= PH_SYNC;
               sync_cnt <= '0;
            end
            PH_SYNC: begin
               if (rise) begin
                  if (sync_cnt == SYNC_END) begin
                     phase    <= PH_DATA;
                     slot     <= '0;
                     shreg    <= byte_in;
                     line_oe  <= 1'b1;
                     line_out <= byte_in[DATA_W-1];
                  end else begin
                     sync_cnt <= sync_cnt + SCW'(1);
                  end
               end
            end
            default: begin
               if (rise) begin
                  if (slot == HIZ_SLOT) begin
                     slot     <= '0;
                     shreg    <= byte_in;
                     line_oe  <= 1'b1;
                     line_out <= byte_in[DATA_W-1];
                  end else if (slot + SLW'(1) == HIZ_SLOT) begin
                     slot      <= HIZ_SLOT;
                     line_oe   <= 1'b0;
                     byte_done <= 1'b1;
                  end else begin
                     slot     <= slot + SLW'(1);
                     shreg    <= shreg << 1;
                     line_out <= shreg[DATA_W-2];
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx #(
   parameter int DEPTH       = 256,
   parameter int DATA_W      = 8,
   parameter int SYNC_EDGES  = 9,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_in,
   input  logic              tx_enable,
   input  logic              size_256,
   input  logic              sw_access,
   input  logic              sw_ptr_we,
   input  logic [AW-1:0]     sw_ptr_wdata,
   input  logic              sw_step,
   output logic [AW-1:0]     buf_addr,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic              sda_oe,
   output logic              sda_out,
   output logic              byte_irq
);
   logic rise;
   logic run;
   logic done;

   assign run      = tx_enable & ~sw_access;
   assign byte_irq = done;

   ddc1_vsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise(rise)
   );

   ddc1_framer #(.DATA_W(DATA_W), .SYNC_EDGES(SYNC_EDGES)) u_frame (
      .clk(clk), .rst_n(rst_n), .run(run), .rise(rise), .byte_in(buf_rdata),
      .line_oe(sda_oe), .line_out(sda_out), .byte_done(done)
   );

   ddc1_pointer #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .size_full(size_256),
      .load(sw_access & sw_ptr_we), .load_val(sw_ptr_wdata),
      .step((sw_access & sw_step) | done), .ptr(buf_addr)
   );
endmodule

// File: rtl/ddc1_edid_tx_chk.sv
module ddc1_edid_tx_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_enable,
   input logic          size_256,
   input logic          sw_access,
   input logic          sw_ptr_we,
   input logic          sw_step,
   input logic [AW-1:0] buf_addr,
   input logic          sda_oe,
   input logic          byte_irq
);
   p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_irq |=> !byte_irq);

   p_irq_hiz_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_irq |-> !sda_oe);

   p_sw_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_access |=> !sda_oe);

   p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_enable && $past(!tx_enable)) |-> !sda_oe);

   p_full_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_irq && size_256 && !sw_access) |=> buf_addr == $past(buf_addr) + AW'(1));

   p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_access && sw_step && !sw_ptr_we && !size_256 && buf_addr[AW-1]) |=> $stable(buf_addr));
endmodule

bind ddc1_edid_tx ddc1_edid_tx_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .size_256(size_256),
   .sw_access(sw_access), .sw_ptr_we(sw_ptr_we), .sw_step(sw_step),
   .buf_addr(buf_addr), .sda_oe(sda_oe), .byte_irq(byte_irq)
);

// File: tb/tb_ddc1_edid_tx.sv
`timescale 1ns/1ps
module tb_ddc1_edid_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vsync_in = 1'b0;
   logic       tx_enable = 1'b0;
   logic       size_256 = 1'b0;
   logic       sw_access = 1'b0;
   logic       sw_ptr_we = 1'b0;
   logic [7:0] sw_ptr_wdata = 8'd0;
   logic       sw_step = 1'b0;
   logic [7:0] buf_addr;
   logic [7:0] buf_rdata;
   logic       sda_oe, sda_out, byte_irq;

   logic [7:0] mem [256];
   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #4 clk = ~clk;

   assign buf_rdata = mem[buf_addr];

   always @(posedge clk) if (byte_irq) irq_cnt <= irq_cnt + 1;

   ddc1_edid_tx dut (
      .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .tx_enable(tx_enable),
      .size_256(size_256), .sw_access(sw_access), .sw_ptr_we(sw_ptr_we),
      .sw_ptr_wdata(sw_ptr_wdata), .sw_step(sw_step), .buf_addr(buf_addr),
      .buf_rdata(buf_rdata), .sda_oe(sda_oe), .sda_out(sda_out), .byte_irq(byte_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic vper();
      vsync_in = 1'b1;
      repeat (8) @(posedge clk);
      vsync_in = 1'b0;
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_ptr(input logic [7:0] v);
      @(negedge clk);
      sw_access = 1'b1; sw_ptr_we = 1'b1; sw_ptr_wdata = v;
      @(negedge clk);
      sw_ptr_we = 1'b0; sw_access = 1'b0;
      @(negedge clk);
   endtask

   task automatic sync_phase(input string req);
      int hiz = 0;
      for (int i = 0; i < 9; i++) begin
         vper();
         if (!sda_oe) hiz++;
      end
      check(req, hiz, 9);
   endtask

   task automatic send_byte(input logic [7:0] exp, input string req);
      int start = irq_cnt;
      logic [7:0] got = 8'd0;
      int drv = 0;
      for (int i = 7; i >= 0; i--) begin
         vper();
         if (sda_oe) drv++;
         got[i] = sda_out;
      end
      check({req, " driven bits"}, drv, 8);
      check({req, " byte value"}, int'(got), int'(exp));
      vper();
      check({req, " released slot"}, int'(sda_oe), 0);
      check({req, " R7 irq per byte"}, irq_cnt - start, 1);
   endtask

   task automatic t_reset();
      check("R8 reset oe", int'(sda_oe), 0);
      check("R7 reset irq", int'(byte_irq), 0);
      check("R4 reset ptr", int'(buf_addr), 0);
   endtask

   task automatic t_stream();
      size_256 = 1'b1;
      set_ptr(8'd0);
      tx_enable = 1'b1;
      sync_phase("R1 sync hiz");
      send_byte(mem[0], "R2 byte0");
      send_byte(mem[1], "R4 byte1");
      send_byte(mem[2], "R4 byte2");
      check("R4 ptr after 3", int'(buf_addr), 3);
      tx_enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_wrap_half();
      size_256 = 1'b0;
      set_ptr(8'd126);
      tx_enable = 1'b1;
      sync_phase("R1 sync hiz half");
      send_byte(mem[126], "R5 b126");
      send_byte(mem[127], "R5 b127");
      check("R5 wrap to 0", int'(buf_addr), 0);
      send_byte(mem[0], "R5 b0");
      tx_enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_wrap_full();
      size_256 = 1'b1;
      set_ptr(8'd254);
      tx_enable = 1'b1;
      sync_phase("R1 sync hiz full");
      send_byte(mem[254], "R3 b254");
      send_byte(mem[255], "R3 b255");
      check("R3 wrap to 0", int'(buf_addr), 0);
      tx_enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_upper();
      size_256 = 1'b0;
      set_ptr(8'd200);
      check("R6 direct load 200", int'(buf_addr), 200);
      sw_access = 1'b1; sw_step = 1'b1;
      @(negedge clk);
      sw_step = 1'b0;
      @(negedge clk);
      check("R6 no step above 127", int'(buf_addr), 200);
      size_256 = 1'b1;
      sw_step = 1'b1;
      @(negedge clk);
      sw_step = 1'b0;
      @(negedge clk);
      check("R8 sw step full", int'(buf_addr), 201);
      sw_access = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_sw_hold();
      size_256 = 1'b1;
      set_ptr(8'd10);
      tx_enable = 1'b1;
      sync_phase("R1 sync hiz hold");
      vper(); vper();
      sw_access = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 released under sw", int'(sda_oe), 0);
      for (int i = 0; i < 12; i++) vper();
      check("R8 no send under sw oe", int'(sda_oe), 0);
      check("R8 ptr held under sw", int'(buf_addr), 10);
      sw_access = 1'b0;
      tx_enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_disable();
      size_256 = 1'b1;
      set_ptr(8'd20);
      tx_enable = 1'b1;
      sync_phase("R1 sync hiz dis");
      vper(); vper(); vper();
      check("R9 driving mid byte", int'(sda_oe), 1);
      tx_enable = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 released on clear", int'(sda_oe), 0);
      tx_enable = 1'b1;
      sync_phase("R9 fresh sync");
      send_byte(mem[20], "R9 restart byte");
      tx_enable = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 91) ^ (i >> 3));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_stream();
      t_wrap_half();
      t_wrap_full();
      t_upper();
      t_sw_hold();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule